// File: doc/BRIEF.md
# Row Balancing Selector for a Series Chain of Full-Bridge Cells

This block sits between a current regulator and the gate drivers of a stacked converter built from series rows of full-bridge cells. Every cell in a row receives the same command, so the block produces one two-bit state per row. It takes a signed normalized voltage reference in fixed point and rounds it to a whole number of rows. It then ranks the rows by measured storage-capacitor voltage and inserts the required count, in direct or reverse polarity. The ranking direction follows the direction of energy flow, so the capacitors discharge or recharge evenly.

The control rate and the switching rate are separate. The block checks the fault inputs and the capacitor limits on every control tick. The rank and the row commands are refreshed only on every K-th tick. On that tick the block takes a snapshot of the inputs. One cycle later the rank is registered and `upd_done` pulses. The new commands appear on the following edge. A fault, whether from an error flag or from a capacitor voltage outside its window, latches. It forces every switch off until software pulses the clear input.

Top module: `rowbal_top`

## Requirements
- R1: The reference `vref` is a two's-complement value in units of 2^-REF_FRAC. Its magnitude is rounded to the nearest integer, with exact halves rounded away from zero. The result is the number of rows to insert.
- R2: The rounded level saturates at N_ROWS in magnitude, so the output spans 2·N_ROWS+1 levels.
- R3: Each row takes a 2-bit code at bits [2j+1:2j] of `row_cmd`: 00 bypass, 01 direct, 10 reverse, 11 freewheel. Inserted rows use direct when the level is positive and reverse when it is negative.
- R4: Rows that are not inserted receive bypass (00). If `idle_fw` was high on the refresh tick, they receive freewheel (11) instead.
- R5: Exactly |level| rows are inserted on each refresh.
- R6: Energy is drawn from the capacitors when the sign of the level matches the current sign (`i_neg`=0 with a positive level, or `i_neg`=1 with a negative level). In that case the highest-voltage rows are inserted first; otherwise the lowest-voltage rows are inserted first. Equal voltages favour the lower row index.
- R7: A tick with any `err_flags` bit set, or with any row voltage above VCAP_HI or below VCAP_LO, latches a fault. From the next edge, `gate_off` is 1 and every row code is 00.
- R8: A latched fault holds, and no refresh takes place, until `fault_clr` is pulsed. The clear also restarts the tick count. The rows stay at bypass until the next refresh.
- R9: A refresh happens on every K_TICKS-th tick. The inputs are sampled on that tick only, and their values on earlier ticks have no effect.
- R10: `upd_done` is a one-cycle pulse one edge after the refresh tick. The new commands appear one edge after that pulse, and the old ones hold while it is high.
- R11: After reset, all row codes are 00, and `gate_off` and `upd_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Control-rate tick |
| vref | input | REF_W | Signed normalized reference, REF_FRAC fraction bits |
| i_neg | input | 1 | Load current sign, 1 = negative |
| idle_fw | input | 1 | Non-inserted rows freewheel instead of bypass |
| vcap | input | N_ROWS·VCAP_W | Row capacitor voltages, row j at bits [j·VCAP_W +: VCAP_W] |
| err_flags | input | N_FLT | Power-stage error flags |
| fault_clr | input | 1 | Clears the latched fault |
| row_cmd | output | 2·N_ROWS | One state code per row |
| gate_off | output | 1 | Latched fault, all switches off |
| upd_done | output | 1 | Rank complete, new commands on next edge |

## Verification
A wrong rank shows up as a command pattern that names the wrong rows. This appears at the first refresh after the rank logic goes wrong, two edges after the K-th tick, and the bench compares each refresh against its own sorted model. A wrong tick count moves or suppresses the `upd_done` pulse, and the bench checks the pulse at the exact cycle where it should occur. A fault latch that fails to hold or to release shows on `gate_off` and `row_cmd` at the first edge after the tick or the clear.

// File: rtl/rowbal_pkg.sv
package rowbal_pkg;

    typedef enum logic [1:0] {
        RC_BYP = 2'b00,
        RC_DIR = 2'b01,
        RC_REV = 2'b10,
        RC_FW  = 2'b11
    } row_code_e;

endpackage

// File: rtl/level_quantizer.sv
module level_quantizer #(
    parameter int REF_W    = 8,
    parameter int REF_FRAC = 4,
    parameter int N_ROWS   = 4,
    parameter int LVL_W    = 3
) (
    input  logic [REF_W-1:0] vref,
    output logic [LVL_W-1:0] mag,
    output logic             neg
);
    localparam logic [REF_W:0] HALF = (REF_W+1)'(1) << (REF_FRAC - 1);
    localparam logic [REF_W:0] NSAT = (REF_W+1)'(N_ROWS);

    logic [REF_W:0] abs_v;
    logic [REF_W:0] rnd;

    always_comb begin
        if (vref[REF_W-1]) begin
            abs_v = (REF_W+1)'(0) - {vref[REF_W-1], vref};
        end else begin
            abs_v = {1'b0, vref};
        end
        rnd = (abs_v + HALF) >> REF_FRAC;
        if (rnd > NSAT) begin
            mag = LVL_W'(N_ROWS);
        end else begin
            mag = rnd[LVL_W-1:0];
        end
        neg = vref[REF_W-1] && (mag != '0);
    end

endmodule

// File: rtl/fault_guard.sv
module fault_guard #(
    parameter int N_ROWS  = 4,
    parameter int VCAP_W  = 10,
    parameter int N_FLT   = 2,
    parameter int VCAP_HI = 1000,
    parameter int VCAP_LO = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [N_FLT-1:0]         err,
    input  logic [N_ROWS*VCAP_W-1:0] vcap,
    input  logic                     clr,
    output logic                     fault_q,
    output logic                     fault_now
);
    localparam logic [VCAP_W-1:0] HI_V = VCAP_W'(VCAP_HI);
    localparam logic [VCAP_W-1:0] LO_V = VCAP_W'(VCAP_LO);

    logic oob;
    logic fault_d;

    always_comb begin
        oob = 1'b0;
        for (int j = 0; j < N_ROWS; j++) begin
            if (vcap[j*VCAP_W +: VCAP_W] > HI_V || vcap[j*VCAP_W +: VCAP_W] < LO_V) begin
                oob = 1'b1;
            end
        end
        fault_now = tick && ((|err) || oob);
        if (fault_now) begin
            fault_d = 1'b1;
        end else if (clr) begin
            fault_d = 1'b0;
        end else begin
            fault_d = fault_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    // R7: an error flag on a tick trips the latch
    a_r7_flag_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (|err)) |=> fault_q);
    // R8: latch holds without clear
    a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !clr) |=> fault_q);
    // R8: clear releases when no new fault
    a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && clr && !fault_now) |=> !fault_q);

endmodule

// File: rtl/row_ranker.sv
module row_ranker #(
    parameter int N_ROWS = 4,
    parameter int VCAP_W = 10,
    parameter int LVL_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     kill,
    input  logic [N_ROWS*VCAP_W-1:0] vcap,
    input  logic                     desc,
    input  logic [LVL_W-1:0]         lvl,
    output logic                     done,
    output logic [N_ROWS-1:0]        mask
);
    typedef struct packed {
        logic              done;
        logic [LVL_W-1:0]  lvl;
        logic [N_ROWS-1:0] mask;
    } rk_t;

    rk_t r_d, r_q;
    logic [LVL_W-1:0] pos [N_ROWS];

    // position of each row = number of rows ranked ahead of it
    always_comb begin
        for (int j = 0; j < N_ROWS; j++) begin
            pos[j] = '0;
            for (int k = 0; k < N_ROWS; k++) begin
                if (k != j) begin
                    if ((desc  && vcap[k*VCAP_W +: VCAP_W] > vcap[j*VCAP_W +: VCAP_W]) ||
                        (!desc && vcap[k*VCAP_W +: VCAP_W] < vcap[j*VCAP_W +: VCAP_W]) ||
                        (vcap[k*VCAP_W +: VCAP_W] == vcap[j*VCAP_W +: VCAP_W] && k < j)) begin
                        pos[j] = pos[j] + LVL_W'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = start && !kill;
        if (start) begin
            r_d.lvl = lvl;
            for (int j = 0; j < N_ROWS; j++) begin
                r_d.mask[j] = (pos[j] < lvl);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = r_q.done;
    assign mask = r_q.mask;

    // R5: the positions form a permutation, so the insert count matches the level
    a_r5_insert_count: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> ($countones(r_q.mask) == int'(r_q.lvl)));

endmodule

// File: rtl/rowbal_top.sv
module rowbal_top
    import rowbal_pkg::*;
#(
    parameter int N_ROWS   = 4,
    parameter int VCAP_W   = 10,
    parameter int REF_W    = 8,
    parameter int REF_FRAC = 4,
    parameter int N_FLT    = 2,
    parameter int K_TICKS  = 10,
    parameter int VCAP_HI  = 1000,
    parameter int VCAP_LO  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [REF_W-1:0]         vref,
    input  logic                     i_neg,
    input  logic                     idle_fw,
    input  logic [N_ROWS*VCAP_W-1:0] vcap,
    input  logic [N_FLT-1:0]         err_flags,
    input  logic                     fault_clr,
    output logic [2*N_ROWS-1:0]      row_cmd,
    output logic                     gate_off,
    output logic                     upd_done
);
    localparam int LVL_W = $clog2(N_ROWS + 1);
    localparam int CNT_W = (K_TICKS > 1) ? $clog2(K_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(K_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]         cnt;
        logic                     snap_vld;
        logic [N_ROWS*VCAP_W-1:0] vcap;
        logic [LVL_W-1:0]         mag;
        logic                     neg;
        logic                     desc;
        logic                     fw;
        logic                     neg2;
        logic                     fw2;
        logic [2*N_ROWS-1:0]      cmd;
    } st_t;

    st_t s_d, s_q;

    logic [LVL_W-1:0]  lvl_mag;
    logic              lvl_neg;
    logic              fault_q;
    logic              fault_now;
    logic              halt;
    logic              upd;
    logic              rank_done;
    logic [N_ROWS-1:0] rank_mask;

    level_quantizer #(
        .REF_W(REF_W), .REF_FRAC(REF_FRAC), .N_ROWS(N_ROWS), .LVL_W(LVL_W)
    ) u_quant (
        .vref(vref), .mag(lvl_mag), .neg(lvl_neg)
    );

    fault_guard #(
        .N_ROWS(N_ROWS), .VCAP_W(VCAP_W), .N_FLT(N_FLT),
        .VCAP_HI(VCAP_HI), .VCAP_LO(VCAP_LO)
    ) u_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick), .err(err_flags), .vcap(vcap),
        .clr(fault_clr), .fault_q(fault_q), .fault_now(fault_now)
    );

    assign halt = fault_q || fault_now;

    row_ranker #(
        .N_ROWS(N_ROWS), .VCAP_W(VCAP_W), .LVL_W(LVL_W)
    ) u_rank (
        .clk(clk), .rst_n(rst_n), .start(s_q.snap_vld), .kill(halt),
        .vcap(s_q.vcap), .desc(s_q.desc), .lvl(s_q.mag),
        .done(rank_done), .mask(rank_mask)
    );

    always_comb begin
        s_d          = s_q;
        s_d.snap_vld = 1'b0;
        upd          = tick && (s_q.cnt == CNT_LAST) && !halt;

        // tick counter
        if (halt) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = (s_q.cnt == CNT_LAST) ? '0 : s_q.cnt + CNT_W'(1);
        end

        // snapshot on the refresh tick
        if (upd) begin
            s_d.snap_vld = 1'b1;
            s_d.vcap     = vcap;
            s_d.mag      = lvl_mag;
            s_d.neg      = lvl_neg;
            s_d.desc     = (lvl_mag != '0) && (lvl_neg == i_neg);
            s_d.fw       = idle_fw;
        end

        // carry polarity alongside the rank stage
        if (s_q.snap_vld) begin
            s_d.neg2 = s_q.neg;
            s_d.fw2  = s_q.fw;
        end

        // command register
        if (halt) begin
            s_d.cmd = '0;
        end else if (rank_done) begin
            for (int j = 0; j < N_ROWS; j++) begin
                if (rank_mask[j]) begin
                    s_d.cmd[2*j +: 2] = s_q.neg2 ? RC_REV : RC_DIR;
                end else begin
                    s_d.cmd[2*j +: 2] = s_q.fw2 ? RC_FW : RC_BYP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row_cmd  = s_q.cmd;
    assign gate_off = fault_q;
    assign upd_done = rank_done;

    // R2: level never exceeds the row count
    a_r2_level_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl_mag) <= N_ROWS);
    // R7: latched fault means every row is off
    a_r7_off_when_fault: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |-> (row_cmd == '0));
    // R10: commands only move right after a done pulse
    a_r10_cmd_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_off && !$stable(row_cmd)) |-> $past(upd_done));
    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

endmodule

// File: tb/sim_rowbal_top.sv
`timescale 1ns/1ps
module sim_rowbal_top;
    localparam int N  = 4;
    localparam int VW = 10;
    localparam int K  = 10;
    localparam real TCLK = 8.0;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic [7:0]     vref = '0;
    logic           i_neg = 1'b0;
    logic           idle_fw = 1'b0;
    logic [N*VW-1:0] vcap = '0;
    logic [1:0]     err_flags = '0;
    logic           fault_clr = 1'b0;
    logic [2*N-1:0] row_cmd;
    logic           gate_off;
    logic           upd_done;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] last_exp = '0;
    bit         done_run = 0;

    always #(TCLK/2) clk = ~clk;

    rowbal_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vref(vref), .i_neg(i_neg),
        .idle_fw(idle_fw), .vcap(vcap), .err_flags(err_flags), .fault_clr(fault_clr),
        .row_cmd(row_cmd), .gate_off(gate_off), .upd_done(upd_done)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(int v0, int v1, int v2, int v3, int r16, bit ineg, bit fw);
        int v[4];
        int mag;
        int r;
        bit neg;
        bit desc;
        bit used[4];
        logic [7:0] res;
        v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
        mag  = (r16 < 0) ? -r16 : r16;
        r    = (mag + 8) / 16;
        if (r > N) r = N;
        neg  = (r16 < 0) && (r != 0);
        desc = (r != 0) && (neg == ineg);
        for (int i = 0; i < 4; i++) begin
            used[i] = 0;
            res[2*i +: 2] = fw ? 2'b11 : 2'b00;
        end
        for (int n = 0; n < r; n++) begin
            int best = -1;
            for (int i = 0; i < 4; i++) begin
                if (!used[i] && (best < 0 || (desc ? v[i] > v[best] : v[i] < v[best]))) best = i;
            end
            used[best] = 1;
            res[2*best +: 2] = neg ? 2'b10 : 2'b01;
        end
        return res;
    endfunction

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    // late=1: earlier ticks see different inputs (R9)
    task automatic run_vec(int v0, int v1, int v2, int v3, int r16, bit ineg, bit fw,
                           bit late, string tag);
        logic [7:0] e;
        e = model(v0, v1, v2, v3, r16, ineg, fw);
        if (late) begin
            vcap  = {10'd900, 10'd20, 10'd900, 10'd20};
            vref  = 8'h70;
            i_neg = ~ineg;
            idle_fw = ~fw;
        end else begin
            vcap  = {VW'(v3), VW'(v2), VW'(v1), VW'(v0)};
            vref  = 8'(r16);
            i_neg = ineg;
            idle_fw = fw;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int t = 0; t < K - 1; t++) one_tick();
        vcap  = {VW'(v3), VW'(v2), VW'(v1), VW'(v0)};
        vref  = 8'(r16);
        i_neg = ineg;
        idle_fw = fw;
        one_tick();
        chk(upd_done == 1'b0, "R10 done early", int'(upd_done), 0);
        @(negedge clk);
        chk(upd_done == 1'b1, "R10 done timing", int'(upd_done), 1);
        chk(row_cmd == last_exp, "R10 old cmd held", int'(row_cmd), int'(last_exp));
        @(negedge clk);
        last_exp = e;
        @(negedge clk);
        @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && upd_done) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected update", int'(row_cmd), 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(row_cmd == e, t, int'(row_cmd), int'(e));
                end
            end
        end
    end

    initial begin
        #(TCLK * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seen;
        vcap = {10'd500, 10'd500, 10'd500, 10'd500};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(row_cmd == '0, "R11 cmd", int'(row_cmd), 0);
        chk(gate_off == 1'b0, "R11 gate_off", int'(gate_off), 0);
        chk(upd_done == 1'b0, "R11 done", int'(upd_done), 0);

        run_vec(100, 400, 300, 200, 24, 0, 0, 0, "R1 R6 1.5 rounds to 2, discharge highest");
        run_vec(100, 400, 300, 200, -24, 1, 0, 0, "R3 R6 negative level reverse, discharge");
        run_vec(100, 400, 300, 200, 32, 1, 0, 0, "R6 charge inserts lowest");
        run_vec(100, 400, 300, 200, -16, 0, 0, 0, "R6 R3 negative charge lowest reverse");
        run_vec(100, 400, 300, 200, 7, 0, 0, 0, "R1 0.44 rounds to zero, R4 bypass");
        run_vec(100, 400, 300, 200, 7, 0, 1, 0, "R4 idle rows freewheel");
        run_vec(100, 400, 300, 200, 24, 0, 1, 0, "R4 R5 mixed insert and freewheel");
        run_vec(100, 400, 300, 200, 127, 0, 0, 0, "R2 saturate positive");
        run_vec(100, 400, 300, 200, -128, 1, 0, 0, "R2 saturate negative");
        run_vec(250, 250, 250, 250, 16, 0, 0, 0, "R6 tie lower index, descending");
        run_vec(250, 250, 250, 250, 16, 1, 0, 0, "R6 tie lower index, ascending");
        run_vec(50, 60, 60, 40, 40, 0, 0, 0, "R1 half 2.5 rounds away to 3, R5");
        run_vec(50, 60, 60, 40, -8, 1, 0, 0, "R1 half -0.5 rounds to -1");
        run_vec(300, 200, 100, 400, 48, 0, 0, 1, "R9 only refresh tick sampled");

        // R7 error flag
        err_flags = 2'b01;
        one_tick();
        chk(gate_off == 1'b1, "R7 flag trips", int'(gate_off), 1);
        chk(row_cmd == '0, "R7 all off", int'(row_cmd), 0);
        err_flags = '0;
        seen = 0;
        for (int t = 0; t < K + 2; t++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            if (upd_done) seen++;
        end
        @(negedge clk);
        if (upd_done) seen++;
        chk(seen == 0, "R8 no refresh while latched", seen, 0);
        chk(gate_off == 1'b1, "R8 fault holds", int'(gate_off), 1);
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
        chk(gate_off == 1'b0, "R8 clear", int'(gate_off), 0);
        chk(row_cmd == '0, "R8 bypass after clear", int'(row_cmd), 0);
        last_exp = '0;
        run_vec(100, 400, 300, 200, 16, 0, 0, 0, "R8 count restarts after clear");

        // R7 voltage out of window
        vcap = {10'd1010, 10'd300, 10'd300, 10'd300};
        one_tick();
        chk(gate_off == 1'b1, "R7 high limit trips", int'(gate_off), 1);
        chk(row_cmd == '0, "R7 all off on limit", int'(row_cmd), 0);
        vcap = {10'd300, 10'd300, 10'd300, 10'd300};
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
        last_exp = '0;
        vcap = {10'd300, 10'd300, 10'd300, 10'd5};
        one_tick();
        chk(gate_off == 1'b1, "R7 low limit trips", int'(gate_off), 1);
        vcap = {10'd300, 10'd300, 10'd300, 10'd300};
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
        last_exp = '0;
        run_vec(500, 500, 700, 100, -40, 1, 1, 0, "R3 R4 R6 resume after fault");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all refreshes observed", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule